// File: doc/BRIEF.md
# Single-error-correcting memory with background scrub

This block is a small synchronous storage array whose words are kept as 136-bit codewords: 128 data bits plus 8 check bits. The check bits are generated from the write data on every host write and stored in the same word. On a host read the codeword is decoded. A single flipped bit anywhere in the 136 bits is repaired on the way out, and the data is returned one cycle later with a flag that marks the correction. The read path never writes the repaired word back, so a flipped bit stays in the array.

A background scrub engine repairs the array. It visits one word after each programmable number of idle cycles and walks the addresses in ascending order. For each word it reads the codeword, decodes it, and writes back a re-encoded, repaired codeword if it finds a correctable error. Host accesses always win over the scrub engine. If the host, or the test fault-injection port, changes a word between the scrub read and the scrub write, the engine drops its stale result. A saturating counter totals every correction: those seen on host reads and those repaired by the scrub engine.

The block only protects against bits that flip while they are held in the array. A test input flips one chosen stored bit without touching the check bits, so that errors can be created on demand.

Top module: `odecc_mem`

## Requirements
- R1: A host write stores the data with 8 freshly computed check bits. A later read of an undisturbed word returns the written data with `corr_o` and `uncorr_o` both low.
- R2: `rvalid_o` is high in exactly the cycle after a read request (`req_i` high, `we_i` low). `rdata_o`, `corr_o` and `uncorr_o` are aligned with it.
- R3: Flipping any single stored bit is corrected on read. Bit index 0..127 is data bit 0..127 and 128..135 is check bit 0..7. The read returns the written data with `corr_o` high and `uncorr_o` low.
- R4: A host read that corrects an error does not write to the array. A second read of the same word reports `corr_o` again.
- R5: A scrub period of zero stops the scrub engine. A non-zero period P makes it visit one word after P idle cycles, in ascending address order, wrapping from the last address to address 0.
- R6: A scrub visit to a word with a correctable error rewrites a repaired codeword. Later reads of that word return the data with `corr_o` low.
- R7: The scrub engine performs no array access in a cycle with `req_i` high. A host write or fault injection that lands on the word between the scrub read and the scrub write is never overwritten by the scrub engine.
- R8: `err_cnt_o` rises by one for each corrected host read and each scrub repair, saturates at all ones, and changes at no other time.
- R9: A syndrome with no codeword position (value above 136) raises `uncorr_o`, returns the stored data bits unchanged and does not change `err_cnt_o`. Example: flipping check bits 6 and 7 (bit indices 134 and 135) gives syndrome 192.
- R10: `scrub_fix_o` pulses for one cycle per scrub repair. A word with an uncorrectable syndrome is left as stored.
- R11: After reset, every output is zero. Every array word holds all-zero data with all-zero check bits, which reads back clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write when high, read when low |
| addr_i | input | AW | Host word address |
| wdata_i | input | 128 | Host write data |
| rdata_o | output | 128 | Corrected read data, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |
| corr_o | output | 1 | Read data had a corrected single-bit error |
| uncorr_o | output | 1 | Read syndrome matched no codeword position |
| scrub_period_i | input | PW | Idle cycles between scrub visits; zero disables scrub |
| scrub_fix_o | output | 1 | Pulse when the scrub engine rewrote a repaired word |
| err_cnt_o | output | CNT_W | Saturating count of corrections |
| inj_i | input | 1 | Fault injection strobe |
| inj_addr_i | input | AW | Word to disturb |
| inj_bit_i | input | 8 | Codeword bit to invert (0..135) |

## Verification
The bench injects a fault at each of the 136 codeword positions. Each fault must read back corrected twice, because a design that wrote corrections back on reads would report a clean second read. A double flip in the two top check bits must be reported as uncorrectable with untouched data, which catches a decoder that corrects any nonzero syndrome. A scrub sweep must clear exactly the three correctable faults and leave the uncorrectable word alone, and a zero period must leave a fault in place indefinitely. Host writes are interleaved with a one-cycle scrub period at varied phases; an engine without stale-data tracking would restore old data over the new word. The counter is driven into saturation and must hold its maximum.

// File: rtl/odecc_pkg.sv
package odecc_pkg;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned CHK_W  = 8;
  localparam int unsigned CW_W   = DATA_W + CHK_W;
  localparam int unsigned CW_IW  = $clog2(CW_W);

  typedef logic [CHK_W-1:0] syn_t;

  typedef struct packed {
    logic [CHK_W-1:0]  chk;
    logic [DATA_W-1:0] data;
  } cw_t;

  typedef enum logic [1:0] {
    SC_WAIT,
    SC_READ,
    SC_FIX
  } sc_state_e;

  // Hamming position (1-based, skipping powers of two) of data bit idx
  function automatic int unsigned data_pos(int unsigned idx);
    int unsigned p;
    int unsigned n;
    p = 0;
    n = 0;
    for (int unsigned q = 1; q <= CW_W; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == idx) p = q;
        n++;
      end
    end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] chk_mask(int unsigned k);
    logic [DATA_W-1:0] m;
    int unsigned       p;
    m = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      p    = data_pos(i);
      m[i] = p[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/odecc_enc.sv
module odecc_enc
  import odecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [DATA_W-1:0] MASK = chk_mask(k);
    assign chk_o[k] = ^(data_i & MASK);
  end
endmodule

// File: rtl/odecc_dec.sv
module odecc_dec
  import odecc_pkg::*;
(
  input  cw_t               cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  logic [CHK_W-1:0]  chk_calc;
  syn_t              syn;
  logic [DATA_W-1:0] flip;

  odecc_enc u_enc (
    .data_i (cw_i.data),
    .chk_o  (chk_calc)
  );

  assign syn = chk_calc ^ cw_i.chk;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam syn_t POS = syn_t'(data_pos(i));
    assign flip[i] = (syn == POS);
  end

  // power-of-two syndromes hit a check bit: data passes, still a correction
  assign corr_o   = (syn != '0) && (syn <= syn_t'(CW_W));
  assign uncorr_o = (syn > syn_t'(CW_W));
  assign data_o   = cw_i.data ^ flip;
endmodule

// File: rtl/odecc_scrub.sv
module odecc_scrub
  import odecc_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] period_i,
  input  logic          host_busy_i,
  input  logic          host_wr_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          inj_i,
  input  logic [AW-1:0] inj_addr_i,
  input  cw_t           rd_cw_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          we_o,
  output cw_t           wcw_o,
  output logic          fix_o,
  output logic          idle_o
);
  sc_state_e         st_q;
  logic [PW-1:0]     tick_q;
  logic [AW-1:0]     addr_q;
  cw_t               hold_q;
  logic              stale_q;
  logic              hit;
  logic [DATA_W-1:0] fix_data;
  logic [CHK_W-1:0]  fix_chk;
  logic              fix_corr;
  logic              fix_unc;

  odecc_dec u_dec (
    .cw_i     (hold_q),
    .data_o   (fix_data),
    .corr_o   (fix_corr),
    .uncorr_o (fix_unc)
  );

  odecc_enc u_enc (
    .data_i (fix_data),
    .chk_o  (fix_chk)
  );

  // any change to the word under repair since it was captured
  assign hit = (host_wr_i && host_addr_i == addr_q) ||
               (inj_i && inj_addr_i == addr_q);

  assign addr_o = addr_q;
  assign idle_o = (st_q == SC_WAIT);
  assign rd_o   = (st_q == SC_READ) && !host_busy_i;
  assign we_o   = (st_q == SC_FIX) && !host_busy_i && !stale_q && !hit &&
                  fix_corr && !fix_unc;
  assign wcw_o  = '{chk: fix_chk, data: fix_data};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SC_WAIT;
      tick_q  <= '0;
      addr_q  <= '0;
      hold_q  <= '0;
      stale_q <= 1'b0;
      fix_o   <= 1'b0;
    end else begin
      fix_o <= we_o;
      unique case (st_q)
        SC_WAIT: begin
          if (period_i == '0) begin
            tick_q <= '0;
          end else if (tick_q >= period_i - PW'(1)) begin
            tick_q <= '0;
            st_q   <= SC_READ;
          end else begin
            tick_q <= tick_q + PW'(1);
          end
        end
        SC_READ: begin
          if (!host_busy_i) begin
            hold_q  <= rd_cw_i;
            stale_q <= hit;
            st_q    <= SC_FIX;
          end
        end
        SC_FIX: begin
          if (hit) stale_q <= 1'b1;
          if (!host_busy_i) begin
            stale_q <= 1'b0;
            addr_q  <= addr_q + AW'(1);
            st_q    <= SC_WAIT;
          end
        end
        default: st_q <= SC_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/odecc_mem.sv
module odecc_mem
  import odecc_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned PW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              corr_o,
  output logic              uncorr_o,
  input  logic [PW-1:0]     scrub_period_i,
  output logic              scrub_fix_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  input  logic              inj_i,
  input  logic [AW-1:0]     inj_addr_i,
  input  logic [CW_IW-1:0]  inj_bit_i
);
  localparam int unsigned DEPTH = 1 << AW;

  cw_t               mem_q [DEPTH];
  logic              host_wr;
  logic              host_rd;
  logic [CHK_W-1:0]  wr_chk;
  cw_t               rd_cw;
  logic [DATA_W-1:0] rd_data;
  logic              rd_corr;
  logic              rd_unc;
  logic [AW-1:0]     sc_addr;
  cw_t               sc_cw;
  cw_t               sc_wcw;
  logic              sc_rd;
  logic              sc_we;
  logic              sc_idle;
  logic              bump;

  assign host_wr = req_i & we_i;
  assign host_rd = req_i & ~we_i;
  assign rd_cw   = mem_q[addr_i];
  assign sc_cw   = mem_q[sc_addr];

  odecc_enc u_wenc (
    .data_i (wdata_i),
    .chk_o  (wr_chk)
  );

  odecc_dec u_rdec (
    .cw_i     (rd_cw),
    .data_o   (rd_data),
    .corr_o   (rd_corr),
    .uncorr_o (rd_unc)
  );

  odecc_scrub #(
    .AW (AW),
    .PW (PW)
  ) u_scrub (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_i    (scrub_period_i),
    .host_busy_i (req_i),
    .host_wr_i   (host_wr),
    .host_addr_i (addr_i),
    .inj_i       (inj_i),
    .inj_addr_i  (inj_addr_i),
    .rd_cw_i     (sc_cw),
    .addr_o      (sc_addr),
    .rd_o        (sc_rd),
    .we_o        (sc_we),
    .wcw_o       (sc_wcw),
    .fix_o       (scrub_fix_o),
    .idle_o      (sc_idle)
  );

  // array: injection first so a same-cycle write to that word wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (inj_i && inj_bit_i < CW_IW'(CW_W))
        mem_q[inj_addr_i][inj_bit_i] <= ~mem_q[inj_addr_i][inj_bit_i];
      if (host_wr)
        mem_q[addr_i] <= '{chk: wr_chk, data: wdata_i};
      else if (sc_we)
        mem_q[sc_addr] <= sc_wcw;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      corr_o   <= 1'b0;
      uncorr_o <= 1'b0;
    end else begin
      rvalid_o <= host_rd;
      corr_o   <= host_rd & rd_corr;
      uncorr_o <= host_rd & rd_unc;
      if (host_rd) rdata_o <= rd_data;
    end
  end

  assign bump = (host_rd & rd_corr) | sc_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_o <= '0;
    end else if (bump && err_cnt_o != '1) begin
      err_cnt_o <= err_cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/odecc_mem_chk.sv
module odecc_mem_chk #(
  parameter int unsigned PW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             rvalid_o,
  input logic             corr_o,
  input logic             uncorr_o,
  input logic             scrub_fix_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [PW-1:0]    scrub_period_i,
  input logic             sc_rd,
  input logic             sc_we,
  input logic             sc_idle
);
  a_r2_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rvalid_o == $past(req_i && !we_i));

  a_r3_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && uncorr_o));

  a_r3_flags_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o || uncorr_o) |-> rvalid_o);

  a_r7_scrub_yields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !(sc_rd || sc_we));

  a_r5_off_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scrub_period_i == '0 && sc_idle) |=> sc_idle);

  a_r8_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_cnt_o == $past(err_cnt_o)) ||
             (err_cnt_o == CNT_W'($past(err_cnt_o) + CNT_W'(1))));

  a_r8_cnt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (err_cnt_o != $past(err_cnt_o)) -> (corr_o || scrub_fix_o));

  a_r10_fix_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (scrub_fix_o && $past(err_cnt_o) != '1) ->
             (err_cnt_o == CNT_W'($past(err_cnt_o) + CNT_W'(1))));
endmodule

bind odecc_mem odecc_mem_chk #(
  .PW    (PW),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .rvalid_o       (rvalid_o),
  .corr_o         (corr_o),
  .uncorr_o       (uncorr_o),
  .scrub_fix_o    (scrub_fix_o),
  .err_cnt_o      (err_cnt_o),
  .scrub_period_i (scrub_period_i),
  .sc_rd          (sc_rd),
  .sc_we          (sc_we),
  .sc_idle        (sc_idle)
);

// File: tb/odecc_mem_tb_top.sv
`timescale 1ns/1ps
module odecc_mem_tb_top;
  localparam int AW    = 4;
  localparam int PW    = 16;
  localparam int CNT_W = 9;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic             we = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [127:0]     wdata = '0;
  logic [127:0]     rdata;
  logic             rvalid, corr, uncorr, fix;
  logic [PW-1:0]    period = '0;
  logic [CNT_W-1:0] cnt;
  logic             inj = 1'b0;
  logic [AW-1:0]    inj_addr = '0;
  logic [7:0]       inj_bit = '0;

  int tests = 0;
  int fails = 0;
  int fix_seen = 0;
  bit done = 1'b0;
  logic [127:0] ref_q [DEPTH];
  logic [127:0] rd_d;
  logic rd_c, rd_u, rd_v;
  int exp_cnt;

  always #4 clk = ~clk;

  odecc_mem #(.AW(AW), .PW(PW), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .corr_o(corr),
    .uncorr_o(uncorr), .scrub_period_i(period), .scrub_fix_o(fix),
    .err_cnt_o(cnt), .inj_i(inj), .inj_addr_i(inj_addr), .inj_bit_i(inj_bit)
  );

  always @(negedge clk) if (rst_n && fix) fix_seen++;

  function automatic logic [127:0] pat(int a, int s);
    logic [31:0] w;
    w = 32'h9E37_79B9 * 32'(a + 1) + 32'h0101_0101 * 32'(s);
    return {w, ~w, w ^ 32'hA5A5_A5A5, w[15:0], w[31:16]};
  endfunction

  task automatic check(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_write(int a, logic [127:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(int a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk); req = 1'b0;
    rd_d = rdata; rd_c = corr; rd_u = uncorr; rd_v = rvalid;
  endtask

  task automatic do_inject(int a, int b);
    @(negedge clk); inj = 1'b1; inj_addr = AW'(a); inj_bit = 8'(b);
    @(negedge clk); inj = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(rdata == '0 && !rvalid && !corr && !uncorr && !fix, "R11", "outputs after reset",
          {rdata[123:0], rvalid, corr, uncorr, fix}, '0);
    check(cnt == '0, "R11", "counter after reset", 128'(cnt), '0);
    do_read(5);
    check(rd_v && rd_d == '0 && !rd_c && !rd_u, "R11", "zero word reads clean",
          {rd_d[124:0], rd_v, rd_c, rd_u}, 128'b100);

    // R1 / R2: write all words, read back clean
    for (int i = 0; i < DEPTH; i++) begin
      ref_q[i] = pat(i, 0);
      do_write(i, ref_q[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      do_read(i);
      check(rd_v && rd_d == ref_q[i] && !rd_c && !rd_u, "R1", "clean readback", rd_d, ref_q[i]);
    end
    @(negedge clk);
    check(!rvalid, "R2", "valid drops after one cycle", 128'(rvalid), '0);

    // R3 / R4: every codeword bit, corrected twice without write-back
    exp_cnt = 0;
    for (int b = 0; b < 136; b++) begin
      int a = b % DEPTH;
      do_inject(a, b);
      do_read(a);
      check(rd_v && rd_c && !rd_u && rd_d == ref_q[a], "R3", $sformatf("flip bit %0d", b),
            rd_d, ref_q[a]);
      do_read(a);
      check(rd_c && rd_d == ref_q[a], "R4", $sformatf("still faulty bit %0d", b),
            128'(rd_c), 128'(1));
      exp_cnt += 2;
      do_write(a, ref_q[a]);
    end
    check(int'(cnt) == exp_cnt, "R8", "count after sweep", 128'(cnt), 128'(exp_cnt));

    // R9: double flip of check bits 6,7 gives syndrome 192
    do_inject(3, 134);
    do_inject(3, 135);
    do_read(3);
    check(rd_u && !rd_c && rd_d == ref_q[3], "R9", "uncorrectable passthrough", rd_d, ref_q[3]);
    check(int'(cnt) == exp_cnt, "R9", "no count on uncorrectable", 128'(cnt), 128'(exp_cnt));
    do_write(3, ref_q[3]);

    // R6 / R10: scrub sweep
    do_inject(2, 7);
    do_inject(9, 100);
    do_inject(15, 130);
    do_inject(6, 134);
    do_inject(6, 135);
    fix_seen = 0;
    period = PW'(20);
    idle(420);
    period = '0;
    idle(6);
    check(fix_seen == 3, "R10", "scrub repair pulses", 128'(fix_seen), 128'(3));
    exp_cnt += 3;
    check(int'(cnt) == exp_cnt, "R8", "scrub repairs counted", 128'(cnt), 128'(exp_cnt));
    do_read(2);
    check(!rd_c && rd_d == ref_q[2], "R6", "word 2 repaired", {rd_d[126:0], rd_c}, {ref_q[2][126:0], 1'b0});
    do_read(9);
    check(!rd_c && rd_d == ref_q[9], "R6", "word 9 repaired", {rd_d[126:0], rd_c}, {ref_q[9][126:0], 1'b0});
    do_read(15);
    check(!rd_c && !rd_u && rd_d == ref_q[15], "R6", "check-bit fault repaired", 128'(rd_c), '0);
    do_read(6);
    check(rd_u, "R10", "uncorrectable word untouched", 128'(rd_u), 128'(1));
    do_write(6, ref_q[6]);

    // R5: zero period leaves a fault in place
    do_inject(4, 50);
    idle(500);
    do_read(4);
    check(rd_c && rd_d == ref_q[4], "R5", "scrub disabled", 128'(rd_c), 128'(1));
    for (int k = 0; k < 240; k++) do_read(4);
    check(cnt == '1, "R8", "counter saturates", 128'(cnt), 128'((1 << CNT_W) - 1));
    do_write(4, ref_q[4]);

    // R7: host writes racing the scrub engine at varied phases
    period = PW'(1);
    for (int j = 0; j < 96; j++) begin
      int a = j % DEPTH;
      do_inject(a, j % 136);
      idle(j % 4);
      ref_q[a] = pat(a, j + 1);
      do_write(a, ref_q[a]);
      idle((j / 4) % 3);
    end
    period = '0;
    idle(6);
    for (int i = 0; i < DEPTH; i++) begin
      do_read(i);
      check(!rd_c && !rd_u && rd_d == ref_q[i], "R7", $sformatf("host write kept at %0d", i),
            rd_d, ref_q[i]);
    end

    done = 1'b1;
    summary();
  end
endmodule